// File: doc/BRIEF.md
# Shared Packet Buffer Pool Manager

This block tracks ownership of a small pool of equal-sized packet buffers that the transmit and receive paths share, and it moves buffer numbers between the queues that link those paths. An allocation port hands out the lowest-numbered idle buffer. A release port and the transmitter's completion input give buffers back. Three first-in first-out queues hold buffer numbers: buffers waiting to transmit, finished transmit buffers waiting for the host, and received buffers waiting for the host. The buffer contents and the host register decoding sit outside this block.

When a transmit completes, one of two things happens. If automatic release is selected, the buffer goes straight back to the pool. Otherwise its number is parked in the completion queue, and the transmit status bit stays raised until the host has drained that queue. Three status bits are combined with a mask to drive one level-sensitive interrupt line.

Top module: `buf_pool_mgr`

## Requirements
- R1: After reset, every buffer is idle, `free_count` equals the pool size (4), all three queues are empty with heads reading 0x80, `int_status` is 0 and `irq` is 0. A reset in the middle of operation returns the block to this same state.
- R2: `alloc_id` shows the lowest idle buffer number, zero-extended to 8 bits, or the code 0x80 when no buffer is idle. An `alloc_req` at a clock edge while a buffer is idle marks that buffer busy.
- R3: `free_count` gives the number of idle buffers and changes at the edge that commits an allocation or a release. An allocation and a release of a busy buffer at the same edge leave the count unchanged.
- R4: Releasing a buffer that is already idle changes nothing.
- R5: `tx_done` with `auto_rel`=1 returns buffer `tx_done_id` to the pool at that edge and adds no entry to the completion queue.
- R6: `tx_done` with `auto_rel`=0 appends `tx_done_id` to the completion queue only when that queue holds fewer than 4 entries. Otherwise the number is dropped.
- R7: Status bit 1 (transmit) is set by every `tx_done` and is cleared by acknowledge bit 1. It reads 1 whenever the completion queue is non-empty, even after an acknowledge.
- R8: Status bit 0 (receive) is set when a receive-queue push is accepted. Status bit 2 (allocate) is set when an allocation succeeds. An acknowledge bit clears its status bit at the edge, and a set event in the same cycle wins over the acknowledge.
- R9: `irq` is 1 exactly when the bitwise AND of `int_status` and `int_mask` is non-zero.
- R10: Each queue returns buffer numbers in push order. Its head shows the oldest entry, or 0x80 when the queue is empty. A pop on an empty queue leaves the queue unchanged.
- R11: `tx_flush` empties the transmit queue at that edge. A transmit push in the same cycle is discarded.
- R12: A push to a queue that already holds 4 entries is dropped and the count stays at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Take the buffer shown on alloc_id |
| alloc_id | output | 8 | Lowest idle buffer number, or 0x80 |
| free_count | output | 3 | Number of idle buffers |
| rel_req | input | 1 | Return buffer rel_id to the pool |
| rel_id | input | 2 | Buffer to return |
| txq_push | input | 1 | Append txq_push_id to the transmit queue |
| txq_push_id | input | 2 | Buffer number to queue for transmit |
| txq_pop | input | 1 | Remove the transmit queue head |
| tx_flush | input | 1 | End of a transmit pass; empties the transmit queue |
| txq_head | output | 8 | Oldest transmit entry, or 0x80 |
| txq_count | output | 3 | Transmit queue occupancy |
| tx_done | input | 1 | Transmitter finished buffer tx_done_id |
| tx_done_id | input | 2 | Finished buffer number |
| auto_rel | input | 1 | Free finished buffers instead of queueing them |
| done_pop | input | 1 | Remove the completion queue head |
| done_head | output | 8 | Oldest completion entry, or 0x80 |
| rxq_push | input | 1 | Append rxq_push_id to the receive queue |
| rxq_push_id | input | 2 | Received buffer number |
| rxq_pop | input | 1 | Remove the receive queue head |
| rxq_head | output | 8 | Oldest receive entry, or 0x80 |
| int_mask | input | 3 | Interrupt enable per status bit |
| int_ack | input | 3 | Clear-pulse per status bit |
| int_status | output | 3 | Bit 0 receive, bit 1 transmit, bit 2 allocate |
| irq | output | 1 | Level interrupt |

## Verification
The main collision is an allocation and a release landing on the same edge. The bench raises `alloc_req` and `rel_req` in one cycle and then expects the count to stay the same, the released buffer to be shown as the next lowest idle buffer, and the allocated one to be busy. The second collision is a status set event and its acknowledge in the same cycle. A successful allocation is driven together with acknowledge bit 2, and the bit must remain set. An acknowledge of the transmit bit while completion entries are still queued must also leave that bit at 1. Other collisions covered are a flush together with a push, a push to a full queue, and a pop from an empty queue. For each, the bench compares the occupancy and the head value against what the requirements predict.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    localparam logic [7:0] NO_BUF   = 8'h80;
    localparam int         ST_RCV   = 0;
    localparam int         ST_TX    = 1;
    localparam int         ST_ALLOC = 2;
    localparam int         ST_W     = 3;
endpackage

// File: rtl/pbm_alloc.sv
module pbm_alloc
    import pbm_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int IDX_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             rel_a_req,
    input  logic [IDX_W-1:0] rel_a_id,
    input  logic             rel_b_req,
    input  logic [IDX_W-1:0] rel_b_id,
    output logic [7:0]       alloc_id,
    output logic             alloc_ok,
    output logic [CNT_W-1:0] free_cnt
);
    typedef struct packed {
        logic [NUM_BUF-1:0] used;
    } st_t;

    st_t              s_d, s_q;
    logic [IDX_W-1:0] pick;
    logic             pick_ok;

    always_comb begin
        pick     = '0;
        pick_ok  = 1'b0;
        free_cnt = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (!s_q.used[i]) begin
                pick     = IDX_W'(i);
                pick_ok  = 1'b1;
                free_cnt = free_cnt + 1'b1;
            end
        end
        alloc_ok = alloc_req && pick_ok;
        alloc_id = pick_ok ? {{(8-IDX_W){1'b0}}, pick} : NO_BUF;
        s_d = s_q;
        if (alloc_ok) s_d.used[pick] = 1'b1;
        // only busy buffers may be returned; an idle one is left alone
        if (rel_a_req && s_q.used[rel_a_id]) s_d.used[rel_a_id] = 1'b0;
        if (rel_b_req && s_q.used[rel_b_id]) s_d.used[rel_b_id] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_take_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ok && !rel_a_req && !rel_b_req) |=> (int'(free_cnt) == int'($past(free_cnt)) - 1));
    assert_none_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0) |-> (alloc_id == NO_BUF));
    assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_a_req && !s_q.used[rel_a_id] && !alloc_req && !rel_b_req) |=> $stable(free_cnt));
endmodule

// File: rtl/pbm_queue.sv
module pbm_queue
    import pbm_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    parameter int PTR_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_id,
    input  logic             pop,
    input  logic             flush,
    output logic             accepted,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] slot;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } st_t;

    st_t  s_d, s_q;
    logic take, give;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        take     = push && !flush && (s_q.cnt < CNT_W'(DEPTH));
        give     = pop && !flush && (s_q.cnt != '0);
        accepted = take;
        count    = s_q.cnt;
        head     = (s_q.cnt == '0) ? NO_BUF : {{(8-IDX_W){1'b0}}, s_q.slot[s_q.rd]};
        s_d = s_q;
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (take) begin
                s_d.slot[s_q.wr] = push_id;
                s_d.wr           = step(s_q.wr);
            end
            if (give) s_d.rd = step(s_q.rd);
            case ({take, give})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_full_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH)));
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count == '0) |=> (count == '0 && head == NO_BUF));
    assert_flush_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/pbm_irq.sv
module pbm_irq
    import pbm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_evt,
    input  logic            tx_evt,
    input  logic            alloc_evt,
    input  logic            tx_pending,
    input  logic [ST_W-1:0] ack,
    input  logic [ST_W-1:0] mask,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    typedef struct packed {
        logic [ST_W-1:0] lat;
    } st_t;

    st_t             s_d, s_q;
    logic [ST_W-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[ST_RCV]   = rx_evt;
        set_vec[ST_TX]    = tx_evt;
        set_vec[ST_ALLOC] = alloc_evt;
        s_d.lat = set_vec | (s_q.lat & ~ack);
        status  = s_q.lat;
        status[ST_TX] = s_q.lat[ST_TX] | tx_pending;
        irq = |(status & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_tx_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pending |-> status[ST_TX]);
    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[ST_RCV] && !rx_evt) |=> !status[ST_RCV]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_evt |=> status[ST_ALLOC]);
endmodule

// File: rtl/buf_pool_mgr.sv
module buf_pool_mgr
    import pbm_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int QDEPTH  = 4,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int CNT_W  = $clog2(NUM_BUF + 1),
    localparam int QPTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int QCNT_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic [7:0]        alloc_id,
    output logic [CNT_W-1:0]  free_count,
    input  logic              rel_req,
    input  logic [IDX_W-1:0]  rel_id,
    input  logic              txq_push,
    input  logic [IDX_W-1:0]  txq_push_id,
    input  logic              txq_pop,
    input  logic              tx_flush,
    output logic [7:0]        txq_head,
    output logic [QCNT_W-1:0] txq_count,
    input  logic              tx_done,
    input  logic [IDX_W-1:0]  tx_done_id,
    input  logic              auto_rel,
    input  logic              done_pop,
    output logic [7:0]        done_head,
    input  logic              rxq_push,
    input  logic [IDX_W-1:0]  rxq_push_id,
    input  logic              rxq_pop,
    output logic [7:0]        rxq_head,
    input  logic [ST_W-1:0]   int_mask,
    input  logic [ST_W-1:0]   int_ack,
    output logic [ST_W-1:0]   int_status,
    output logic              irq
);
    logic              alloc_ok;
    logic              tx_auto_free, tx_park;
    logic              txq_acc, done_acc, rxq_acc;
    logic [QCNT_W-1:0] done_count, rxq_count;

    assign tx_auto_free = tx_done && auto_rel;
    assign tx_park      = tx_done && !auto_rel;

    pbm_alloc #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
        .rel_a_req(rel_req), .rel_a_id(rel_id),
        .rel_b_req(tx_auto_free), .rel_b_id(tx_done_id),
        .alloc_id(alloc_id), .alloc_ok(alloc_ok), .free_cnt(free_count)
    );

    pbm_queue #(.DEPTH(QDEPTH), .IDX_W(IDX_W), .PTR_W(QPTR_W), .CNT_W(QCNT_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(txq_push), .push_id(txq_push_id),
        .pop(txq_pop), .flush(tx_flush), .accepted(txq_acc),
        .head(txq_head), .count(txq_count)
    );

    pbm_queue #(.DEPTH(QDEPTH), .IDX_W(IDX_W), .PTR_W(QPTR_W), .CNT_W(QCNT_W)) u_doneq (
        .clk(clk), .rst_n(rst_n), .push(tx_park), .push_id(tx_done_id),
        .pop(done_pop), .flush(1'b0), .accepted(done_acc),
        .head(done_head), .count(done_count)
    );

    pbm_queue #(.DEPTH(QDEPTH), .IDX_W(IDX_W), .PTR_W(QPTR_W), .CNT_W(QCNT_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rxq_push), .push_id(rxq_push_id),
        .pop(rxq_pop), .flush(1'b0), .accepted(rxq_acc),
        .head(rxq_head), .count(rxq_count)
    );

    pbm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .rx_evt(rxq_acc), .tx_evt(tx_done),
        .alloc_evt(alloc_ok), .tx_pending(done_count != '0),
        .ack(int_ack), .mask(int_mask), .status(int_status), .irq(irq)
    );

    assert_auto_no_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_auto_free && !done_pop) |=> $stable(done_count));
    assert_park_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_acc |-> (done_count < QCNT_W'(QDEPTH)));
    assert_rx_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_count <= QCNT_W'(QDEPTH)) && (!txq_acc || txq_push));
endmodule

// File: tb/buf_pool_mgr_bench.sv
`timescale 1ns/1ps
module buf_pool_mgr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 0, rel_req = 0, txq_push = 0, txq_pop = 0, tx_flush = 0;
    logic       tx_done = 0, auto_rel = 0, done_pop = 0, rxq_push = 0, rxq_pop = 0;
    logic [1:0] rel_id = 0, txq_push_id = 0, tx_done_id = 0, rxq_push_id = 0;
    logic [2:0] int_mask = 0, int_ack = 0;
    logic [7:0] alloc_id, txq_head, done_head, rxq_head;
    logic [2:0] free_count, txq_count, int_status;
    logic       irq;

    int total = 0;
    int bad   = 0;
    logic [1:0] exp_rx[$];
    logic [1:0] exp_done[$];

    buf_pool_mgr u_buf_pool_mgr (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_alloc(input int exp_id);
        check("R2 alloc_id before take", alloc_id, exp_id);
        alloc_req = 1; tick(); alloc_req = 0;
    endtask

    task automatic do_rel(input logic [1:0] id);
        rel_id = id; rel_req = 1; tick(); rel_req = 0;
    endtask

    task automatic do_txdone(input logic [1:0] id, input logic ar, input bit kept);
        tx_done_id = id; auto_rel = ar; tx_done = 1;
        if (!ar && kept) exp_done.push_back(id);
        tick(); tx_done = 0; auto_rel = 0;
    endtask

    task automatic do_rxpush(input logic [1:0] id, input bit kept);
        rxq_push_id = id; rxq_push = 1;
        if (kept) exp_rx.push_back(id);
        tick(); rxq_push = 0;
    endtask

    task automatic do_ack(input logic [2:0] a);
        int_ack = a; tick(); int_ack = 0;
    endtask

    // scoreboard monitor: compares popped heads with expected items
    initial forever begin
        @(negedge clk);
        #1.25;
        if (rxq_pop) begin
            if (exp_rx.size() > 0) check("R10 rx order", rxq_head, {6'b0, exp_rx.pop_front()});
            else                   check("R10 rx empty head", rxq_head, 8'h80);
        end
        if (done_pop) begin
            if (exp_done.size() > 0) check("R6 done order", done_head, {6'b0, exp_done.pop_front()});
            else                     check("R6 done empty head", done_head, 8'h80);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 free_count", free_count, 4);
        check("R1 alloc_id", alloc_id, 0);
        check("R1 txq_head", txq_head, 8'h80);
        check("R1 done_head", done_head, 8'h80);
        check("R1 rxq_head", rxq_head, 8'h80);
        check("R1 status", int_status, 0);
        check("R1 irq", irq, 0);

        // R2 lowest-first allocation
        do_alloc(0); do_alloc(1); do_alloc(2);
        check("R3 free after three", free_count, 1);
        check("R8 alloc status", int_status[2], 1);
        do_rel(1);
        check("R3 free after release", free_count, 2);
        check("R2 lowest reused", alloc_id, 1);
        do_rel(1);
        check("R4 idle release count", free_count, 2);
        check("R4 idle release id", alloc_id, 1);

        // R3 alloc and release in the same cycle
        check("R3 pre id", alloc_id, 1);
        alloc_req = 1; rel_id = 0; rel_req = 1; tick(); alloc_req = 0; rel_req = 0;
        check("R3 same-cycle count", free_count, 2);
        check("R3 same-cycle next id", alloc_id, 0);
        do_alloc(0); do_alloc(3);
        check("R2 pool empty code", alloc_id, 8'h80);
        check("R3 none free", free_count, 0);
        alloc_req = 1; tick(); alloc_req = 0;
        check("R2 alloc on empty pool", free_count, 0);

        // R10 R11 R12 transmit queue
        txq_push_id = 2; txq_push = 1; tick();
        txq_push_id = 1; tick(); txq_push = 0;
        check("R10 tx head", txq_head, 2);
        check("R10 tx count", txq_count, 2);
        txq_pop = 1; tick(); txq_pop = 0;
        check("R10 tx head after pop", txq_head, 1);
        txq_push_id = 3; txq_push = 1; tx_flush = 1; tick(); txq_push = 0; tx_flush = 0;
        check("R11 flush count", txq_count, 0);
        check("R11 flush head", txq_head, 8'h80);
        txq_pop = 1; tick(); txq_pop = 0;
        check("R10 pop empty tx", txq_count, 0);
        for (int i = 0; i < 5; i++) begin
            txq_push_id = 2'(i); txq_push = 1; tick();
        end
        txq_push = 0;
        check("R12 full tx count", txq_count, 4);
        check("R12 full tx head", txq_head, 0);
        tx_flush = 1; tick(); tx_flush = 0;

        // R5 auto release
        do_txdone(2, 1, 0);
        check("R5 freed count", free_count, 1);
        check("R5 freed id", alloc_id, 2);
        check("R5 no park", done_head, 8'h80);
        check("R7 tx latched", int_status[1], 1);
        do_ack(3'b010);
        check("R7 tx acked", int_status[1], 0);

        // R6 R7 R9 completion queue
        do_txdone(0, 0, 1); do_txdone(1, 0, 1); do_txdone(3, 0, 1); do_txdone(0, 0, 1);
        do_txdone(1, 0, 0);
        check("R6 bitmap untouched", free_count, 1);
        do_ack(3'b010);
        check("R7 forced while queued", int_status[1], 1);
        int_mask = 3'b010;
        #0.1;
        check("R9 irq tx", irq, 1);
        for (int i = 0; i < 5; i++) begin
            done_pop = 1; tick();
        end
        done_pop = 0;
        check("R7 tx clear when drained", int_status[1], 0);
        check("R9 irq off", irq, 0);

        // R8 ack and set-wins
        do_ack(3'b100);
        check("R8 ack clears alloc", int_status[2], 0);
        check("R8 id before", alloc_id, 2);
        alloc_req = 1; int_ack = 3'b100; tick(); alloc_req = 0; int_ack = 0;
        check("R8 set wins", int_status[2], 1);
        check("R3 free zero", free_count, 0);

        // R8 R10 R12 receive queue
        do_rxpush(1, 1); do_rxpush(3, 1);
        check("R8 rcv set", int_status[0], 1);
        for (int i = 0; i < 3; i++) begin
            rxq_pop = 1; tick();
        end
        rxq_pop = 0;
        check("R10 rx empty", rxq_head, 8'h80);
        do_rxpush(0, 1); do_rxpush(1, 1); do_rxpush(2, 1); do_rxpush(3, 1); do_rxpush(0, 0);
        for (int i = 0; i < 4; i++) begin
            rxq_pop = 1; tick();
        end
        rxq_pop = 0;

        // R9 masking
        int_mask = 3'b000;
        #0.1;
        check("R9 masked", irq, 0);
        int_mask = 3'b001;
        #0.1;
        check("R9 rcv enabled", irq, 1);

        // R1 reset mid-run
        do_rxpush(2, 0);
        rst_n = 0; tick(); tick(); rst_n = 1;
        check("R1 mid reset free", free_count, 4);
        check("R1 mid reset rx", rxq_head, 8'h80);
        check("R1 mid reset status", int_status, 0);

        tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule